// File: doc/BRIEF.md
# Legacy Display Cycle Steering Decoder

This block decides where each processor-initiated memory or I/O request goes. A request can stay on the internal backbone, or it can be forwarded to one of several graphics-attach PCI Express ports. The decision is purely combinational from the current request and the per-port enables.

The decode covers three kinds of space:
- **Legacy colour/VGA space**: memory 0A0000h–0BFFFFh, plus I/O 3B0h–3BBh and 3C0h–3DFh.
- **Monochrome adapter (MDA) space**: memory 0B0000h–0B7FFFh, plus six I/O locations.
- **The 3BCh–3BFh I/O dword**: this is additionally gated by the port's I/O window.

For I/O decode, address bits 15:10 are ignored, so every ISA alias decodes the same as its base address.

A small 8-bit control register, at configuration offset 87h, holds two things. The first is a memory-hole enable that marks 15 MB–16 MB as not claimed by DRAM; a lock input can freeze this bit. The second is one MDA-present bit per port. When a port's MDA-present bit is set, the monochrome ranges are carved out of that port's VGA forwarding, so those requests stay on the backbone.

Top module: `steer_legacy_decode`

## Requirements
- R1: After reset the control register reads 00h at offset 87h. Writes at 87h update bit 7 and bits 3:0. Bits 6:4 always read 0. Reads at any other offset return 00h.
- R2: While `hole_lock_i` is high, a write leaves bit 7 unchanged but still updates bits 3:0.
- R3: `hole_o` is 1 exactly for memory requests with address in F00000h–FFFFFFh while bit 7 is set. It is never 1 for I/O requests.
- R4: A memory request in 0A0000h–0BFFFFh is claimed by port p when all of the following hold: its VGA enable is set, its memory-access enable is set, and the request is not one of the excluded MDA requests. A request in 0B0000h–0B7FFFh is excluded when port p's MDA-present bit (register bit p) is set.
- R5: An I/O request is decoded per enabled byte. Bytes are {addr[15:2], lane} for each set bit of the 4-bit byte enable, and the offset compared is address bits 9:0. A request touching 3B0h–3BBh or 3C0h–3DFh (outside the 3BCh dword) is claimed by a VGA-enabled port with its I/O-access enable set. A byte enable of 0 is never claimed.
- R6: The MDA I/O locations are 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh. With MDA-present set, any I/O span touching one of them stays on the backbone, even if other bytes of the span are VGA locations.
- R7: A request in the 3BCh–3BFh dword is forwarded only when three conditions hold: VGA enable is 1, MDA-present is 0, and the lowest and highest touched byte addresses (full 16 bits) both lie within the port's inclusive base–limit window. Otherwise it stays on the backbone.
- R8: `illegal_o[p]` is 1 when MDA-present is set with VGA enable clear. Such a port is treated as having both bits clear and is never selected.
- R9: `port_sel_o` is zero or one-hot. The lowest-numbered claiming port wins, and `backbone_o` is 1 exactly when no port is selected.
- R10: A memory request is never forwarded to a port with its memory-access enable clear. An I/O request is never forwarded to a port with its I/O-access enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (0 unless offset matches) |
| hole_lock_i | input | 1 | Freezes the hole-enable bit |
| req_is_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr_i | input | ADDR_W | Request address |
| req_be_i | input | 4 | I/O byte enables within the dword |
| port_vga_en_i | input | NPORTS | Per-port VGA enable |
| port_mem_en_i | input | NPORTS | Per-port memory-access enable |
| port_io_en_i | input | NPORTS | Per-port I/O-access enable |
| port_io_base_i | input | NPORTS*16 | Per-port I/O window base, port p at [16p+:16] |
| port_io_limit_i | input | NPORTS*16 | Per-port I/O window limit, inclusive |
| port_sel_o | output | NPORTS | One-hot forward select |
| backbone_o | output | 1 | Request stays on the backbone |
| hole_o | output | 1 | DRAM must not claim this request |
| illegal_o | output | NPORTS | Per-port illegal MDA/VGA combination |

## Verification
A wrong register bit does not show up alone. It changes routing on the very next request that falls in the affected range. A stuck MDA-present bit moves monochrome requests between a port and the backbone, and a stuck hole bit toggles `hole_o` for 15–16 MB addresses. Decode faults are purely combinational, so they appear at the ports in the same cycle as the request. The bench therefore sweeps every enable combination across aliased addresses, every byte-enable span and the range boundaries, and compares each vector immediately.

// File: rtl/steer_pkg.sv
// Shared constants, address classifiers and the request classification
// record used by the legacy steering decoder. Assumes 16-bit I/O addresses
// with aliases folded onto bits 9:0.
package steer_pkg;

    localparam int          IO_W      = 16;
    localparam int          BE_W      = 4;
    localparam logic [9:0]  IO_HI_DW  = 10'h3BC;

    // Monochrome adapter I/O location test on an alias-folded offset
    function automatic logic io_is_mono(input logic [9:0] off);
        return (off == 10'h3B4) || (off == 10'h3B5) || (off == 10'h3B8) ||
               (off == 10'h3B9) || (off == 10'h3BA) || (off == 10'h3BF);
    endfunction

    // Colour/VGA I/O range test on an alias-folded offset
    function automatic logic io_is_vga(input logic [9:0] off);
        return ((off >= 10'h3B0) && (off <= 10'h3BB)) ||
               ((off >= 10'h3C0) && (off <= 10'h3DF));
    endfunction

    typedef struct packed {
        logic              mem_vga;   // memory in 0A0000h-0BFFFFh
        logic              mem_mono;  // memory in 0B0000h-0B7FFFh
        logic              mem_hole;  // memory in 15MB-16MB
        logic              io_any;    // at least one byte enabled
        logic              io_vga;    // some byte in a VGA range
        logic              io_mono;   // some byte on a mono location
        logic              io_hi;     // dword is 3BCh-3BFh
        logic [IO_W-1:0]   io_first;  // lowest touched byte address
        logic [IO_W-1:0]   io_last;   // highest touched byte address
    } req_class_t;

endpackage

// File: rtl/steer_ctrl_reg.sv
// Legacy access control register: hole enable in bit 7, per-port
// mono-present bits in the low bits, remaining bits read as zero.
// Assumes NPORTS <= 4 so the reserved field stays clear.
module steer_ctrl_reg
    import steer_pkg::*;
#(
    parameter int         NPORTS     = 4,
    parameter logic [7:0] CFG_OFFSET = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [7:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              lock_i,
    output logic              hole_en_o,
    output logic [NPORTS-1:0] mono_o,
    output logic [7:0]        rdata_o
);

    logic              hole_q;
    logic [NPORTS-1:0] mono_q;
    logic              hit;

    assign hit = (addr_i == CFG_OFFSET);

    // Register update: hole bit frozen by lock, mono bits always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hole_q <= 1'b0;
            mono_q <= '0;
        end else if (wr_i && hit) begin
            if (!lock_i) hole_q <= wdata_i[7];
            mono_q <= wdata_i[NPORTS-1:0];
        end
    end

    // Read mux: register image at its offset, zero elsewhere
    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[7]          = hole_q;
            rdata_o[NPORTS-1:0] = mono_q;
        end
    end

    assign hole_en_o = hole_q;
    assign mono_o    = mono_q;

endmodule

// File: rtl/steer_req_class.sv
// Classifies one request against the legacy ranges, independent of any
// port. I/O bytes are {addr[15:2], lane}; aliases fold to bits 9:0.
module steer_req_class
    import steer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              is_io_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    output req_class_t        cls_o
);

    // Memory range decode by shifted compare
    always_comb begin
        cls_o.mem_vga  = !is_io_i && ((addr_i >> 17) == ADDR_W'(5));
        cls_o.mem_mono = !is_io_i && ((addr_i >> 15) == ADDR_W'(22));
        cls_o.mem_hole = !is_io_i && ((addr_i >> 20) == ADDR_W'(15));
    end

    // Per-byte I/O decode and span extent
    always_comb begin
        logic [IO_W-1:0] a;
        cls_o.io_any   = 1'b0;
        cls_o.io_vga   = 1'b0;
        cls_o.io_mono  = 1'b0;
        cls_o.io_first = '0;
        cls_o.io_last  = '0;
        cls_o.io_hi    = is_io_i && (addr_i[9:2] == IO_HI_DW[9:2]);
        for (int b = 0; b < BE_W; b++) begin
            a = {addr_i[IO_W-1:2], 2'(b)};
            if (is_io_i && be_i[b]) begin
                if (!cls_o.io_any) cls_o.io_first = a;
                cls_o.io_any  = 1'b1;
                cls_o.io_last = a;
                cls_o.io_vga  = cls_o.io_vga  | io_is_vga(a[9:0]);
                cls_o.io_mono = cls_o.io_mono | io_is_mono(a[9:0]);
            end
        end
    end

endmodule

// File: rtl/steer_port_qual.sv
// Decides whether one port claims the classified request, applying the
// VGA/mono-present pair, the access enables and the I/O window.
module steer_port_qual
    import steer_pkg::*;
(
    input  logic            is_io_i,
    input  req_class_t      cls_i,
    input  logic            vga_en_i,
    input  logic            mono_i,
    input  logic            mem_en_i,
    input  logic            io_en_i,
    input  logic [IO_W-1:0] base_i,
    input  logic [IO_W-1:0] limit_i,
    output logic            claim_o,
    output logic            illegal_o
);

    logic mono_eff, in_win, mem_claim, io_claim;

    // Qualification of memory and I/O claims for this port
    always_comb begin
        mono_eff  = mono_i & vga_en_i;
        illegal_o = mono_i & ~vga_en_i;
        in_win    = (cls_i.io_first >= base_i) && (cls_i.io_last <= limit_i);
        mem_claim = mem_en_i & cls_i.mem_vga & ~(mono_eff & cls_i.mem_mono);
        io_claim  = io_en_i & cls_i.io_any &
                    (cls_i.io_hi ? (~mono_eff & in_win)
                                 : (cls_i.io_vga & ~(mono_eff & cls_i.io_mono)));
        claim_o   = vga_en_i & (is_io_i ? io_claim : mem_claim);
    end

endmodule

// File: rtl/steer_legacy_decode.sv
// Top of the legacy display steering decoder: control register, request
// classifier, one qualifier per port and a lowest-index priority pick.
module steer_legacy_decode
    import steer_pkg::*;
#(
    parameter int         NPORTS     = 4,
    parameter int         ADDR_W     = 32,
    parameter logic [7:0] CFG_OFFSET = 8'h87
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_i,
    input  logic [7:0]             cfg_addr_i,
    input  logic [7:0]             cfg_wdata_i,
    output logic [7:0]             cfg_rdata_o,
    input  logic                   hole_lock_i,
    input  logic                   req_is_io_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [3:0]             req_be_i,
    input  logic [NPORTS-1:0]      port_vga_en_i,
    input  logic [NPORTS-1:0]      port_mem_en_i,
    input  logic [NPORTS-1:0]      port_io_en_i,
    input  logic [NPORTS*16-1:0]   port_io_base_i,
    input  logic [NPORTS*16-1:0]   port_io_limit_i,
    output logic [NPORTS-1:0]      port_sel_o,
    output logic                   backbone_o,
    output logic                   hole_o,
    output logic [NPORTS-1:0]      illegal_o
);

    logic              hole_en;
    logic [NPORTS-1:0] mono;
    logic [NPORTS-1:0] claim;
    req_class_t        cls;

    steer_ctrl_reg #(.NPORTS(NPORTS), .CFG_OFFSET(CFG_OFFSET)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .lock_i(hole_lock_i), .hole_en_o(hole_en),
        .mono_o(mono), .rdata_o(cfg_rdata_o)
    );

    steer_req_class #(.ADDR_W(ADDR_W)) class_i (
        .is_io_i(req_is_io_i), .addr_i(req_addr_i), .be_i(req_be_i),
        .cls_o(cls)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        steer_port_qual qual_i (
            .is_io_i(req_is_io_i), .cls_i(cls),
            .vga_en_i(port_vga_en_i[p]), .mono_i(mono[p]),
            .mem_en_i(port_mem_en_i[p]), .io_en_i(port_io_en_i[p]),
            .base_i(port_io_base_i[p*IO_W +: IO_W]),
            .limit_i(port_io_limit_i[p*IO_W +: IO_W]),
            .claim_o(claim[p]), .illegal_o(illegal_o[p])
        );
    end

    // Lowest-numbered claiming port wins
    always_comb begin
        logic found;
        found      = 1'b0;
        port_sel_o = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (claim[p] && !found) begin
                port_sel_o[p] = 1'b1;
                found         = 1'b1;
            end
        end
        backbone_o = !found;
    end

    // Hole flag for DRAM claim suppression
    assign hole_o = hole_en & cls.mem_hole;

endmodule

// File: rtl/steer_legacy_chk.sv
// Property checker for the steering decoder, bound to the top module.
module steer_legacy_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hole_lock_i,
    input logic              req_is_io_i,
    input logic [NPORTS-1:0] port_mem_en_i,
    input logic [NPORTS-1:0] port_io_en_i,
    input logic [NPORTS-1:0] port_sel_o,
    input logic              backbone_o,
    input logic              hole_o,
    input logic [NPORTS-1:0] illegal_o,
    input logic [7:0]        cfg_rdata_o,
    input logic              hole_en
);

    a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel_o));

    a_r9_backbone_excl: assert property (@(posedge clk) disable iff (!rst_n)
        backbone_o == (port_sel_o == '0));

    a_r8_illegal_unsel: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel_o & illegal_o) == '0);

    a_r10_mem_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !req_is_io_i |-> ((port_sel_o & ~port_mem_en_i) == '0));

    a_r10_io_enable: assert property (@(posedge clk) disable iff (!rst_n)
        req_is_io_i |-> ((port_sel_o & ~port_io_en_i) == '0));

    a_r3_hole_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
        hole_o |-> (!req_is_io_i && hole_en));

    a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hole_lock_i |=> $stable(hole_en));

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[6:4] == 3'b000);

endmodule

bind steer_legacy_decode steer_legacy_chk #(.NPORTS(NPORTS)) chk_i (
    .clk(clk), .rst_n(rst_n), .hole_lock_i(hole_lock_i),
    .req_is_io_i(req_is_io_i), .port_mem_en_i(port_mem_en_i),
    .port_io_en_i(port_io_en_i), .port_sel_o(port_sel_o),
    .backbone_o(backbone_o), .hole_o(hole_o), .illegal_o(illegal_o),
    .cfg_rdata_o(cfg_rdata_o), .hole_en(hole_en)
);

// File: tb/steer_legacy_decode_tb_top.sv
`timescale 1ns/1ps
module steer_legacy_decode_tb_top;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_addr = 8'h00;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    cfg_rdata;
    logic          lock = 1'b0;
    logic          is_io = 1'b0;
    logic [31:0]   addr = '0;
    logic [3:0]    be = '0;
    logic [NP-1:0] vga = '0, mae = '0, iae = '0;
    logic [NP*16-1:0] base = '0, limit = '0;
    logic [NP-1:0] sel, illegal;
    logic          backbone, hole;
    logic [NP-1:0] mono_m = '0;   // bench copy of written mono bits
    logic          hole_m = 1'b0;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    steer_legacy_decode #(.NPORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .hole_lock_i(lock),
        .req_is_io_i(is_io), .req_addr_i(addr), .req_be_i(be),
        .port_vga_en_i(vga), .port_mem_en_i(mae), .port_io_en_i(iae),
        .port_io_base_i(base), .port_io_limit_i(limit),
        .port_sel_o(sel), .backbone_o(backbone), .hole_o(hole),
        .illegal_o(illegal)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h addr=%0h be=%0h io=%0b",
                     req, act, exp, addr, be, is_io);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'h87; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        mono_m = d[NP-1:0];
        if (!lock) hole_m = d[7];
    endtask

    // Expected claim of port p from the requirement text
    function automatic bit exp_claim(input int p);
        bit m, any, vg, md, hi;
        logic [15:0] a, lo_a, hi_a;
        logic [9:0] o;
        m = mono_m[p] & vga[p];
        if (!vga[p]) return 0;
        if (!is_io) begin
            if (!mae[p] || addr < 32'hA0000 || addr > 32'hBFFFF) return 0;
            if (m && addr >= 32'hB0000 && addr <= 32'hB7FFF) return 0;
            return 1;
        end
        if (!iae[p]) return 0;
        any = 0; vg = 0; md = 0; hi = 0; lo_a = 16'hFFFF; hi_a = 16'h0;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                a = (addr[15:0] & 16'hFFFC) + 16'(b);
                o = a[9:0];
                any = 1;
                if (a < lo_a) lo_a = a;
                if (a > hi_a) hi_a = a;
                if (o == 10'h3B4 || o == 10'h3B5 || o == 10'h3B8 ||
                    o == 10'h3B9 || o == 10'h3BA || o == 10'h3BF) md = 1;
                if ((o >= 10'h3B0 && o <= 10'h3BB) ||
                    (o >= 10'h3C0 && o <= 10'h3DF)) vg = 1;
                if (o >= 10'h3BC && o <= 10'h3BF) hi = 1;
            end
        end
        if (!any) return 0;
        if (hi) return !m && lo_a >= base[p*16 +: 16] && hi_a <= limit[p*16 +: 16];
        if (m && md) return 0;
        return vg;
    endfunction

    function automatic logic [NP-1:0] exp_sel();
        for (int p = 0; p < NP; p++) if (exp_claim(p)) return NP'(1) << p;
        return '0;
    endfunction

    task automatic check_route(input string req);
        logic [NP-1:0] e;
        #1;
        e = exp_sel();
        check(sel == e, req, 32'(sel), 32'(e));
        check(backbone == (e == '0), "R9 backbone", 32'(backbone), 32'(e == '0));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] mem_pts [12];
        mem_pts = '{32'h9FFFF, 32'hA0000, 32'hAFFFF, 32'hB0000, 32'hB7FFF,
                    32'hB8000, 32'hBFFFF, 32'hC0000, 32'hEFFFFF, 32'hF00000,
                    32'hFFFFFF, 32'h1000000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and register access
        cfg_addr = 8'h87; #1;
        check(cfg_rdata == 8'h00, "R1 reset value", 32'(cfg_rdata), 0);
        check(backbone == 1'b1 && hole == 1'b0, "R1 reset routing",
              32'({backbone, hole}), 32'h2);
        cfg_write(8'hFF); cfg_addr = 8'h87; #1;
        check(cfg_rdata == 8'h8F, "R1 reserved bits read zero", 32'(cfg_rdata), 32'h8F);
        cfg_addr = 8'h86; #1;
        check(cfg_rdata == 8'h00, "R1 other offset", 32'(cfg_rdata), 0);
        // R2 lock freezes bit 7 only
        lock = 1'b1;
        cfg_write(8'h05); cfg_addr = 8'h87; #1;
        check(cfg_rdata == 8'h85, "R2 locked write", 32'(cfg_rdata), 32'h85);
        lock = 1'b0;
        cfg_write(8'h00); cfg_addr = 8'h87; #1;
        check(cfg_rdata == 8'h00, "R2 unlocked write", 32'(cfg_rdata), 0);

        // R3 R4 R8 R10 memory sweep on port 0
        for (int cfg = 0; cfg < 16; cfg++) begin
            vga = {3'b000, cfg[0]}; mae = {3'b000, cfg[2]}; iae = '0;
            cfg_write({cfg[3], 6'b0, cfg[1]});
            for (int io = 0; io < 2; io++) begin
                for (int i = 0; i < 12; i++) begin
                    is_io = io[0]; addr = mem_pts[i]; be = 4'hF;
                    check_route("R4 memory route");
                    check(hole == (hole_m && !is_io && addr >= 32'hF00000 &&
                                   addr <= 32'hFFFFFF),
                          "R3 hole flag", 32'(hole), 32'(!hole));
                end
            end
            check(illegal[0] == (cfg[1] && !cfg[0]), "R8 illegal flag",
                  32'(illegal[0]), 32'(cfg[1] && !cfg[0]));
        end

        // R5 R6 R7 R8 R10 I/O sweep on port 0 across aliases and spans
        is_io = 1'b1;
        for (int cfg = 0; cfg < 16; cfg++) begin
            vga = {3'b000, cfg[0]}; iae = {3'b000, cfg[2]}; mae = '0;
            cfg_write({7'b0, cfg[1]});
            for (int al = 0; al < 2; al++) begin
                logic [15:0] hi_bits;
                hi_bits = al[0] ? 16'hFC00 : 16'h0000;
                base[15:0]  = cfg[3] ? (hi_bits | 16'h03BD) : 16'h1000;
                limit[15:0] = cfg[3] ? (hi_bits | 16'h03DF) : 16'h1003;
                for (int dw = 16'h3A0; dw <= 16'h3E0; dw += 4) begin
                    for (int b = 0; b < 16; b++) begin
                        addr = 32'(hi_bits | 16'(dw)); be = 4'(b);
                        check_route("R5 R6 R7 io route");
                    end
                end
            end
        end

        // R9 priority across ports
        is_io = 1'b0; addr = 32'hA8000;
        vga = '1; mae = '1; iae = '1;
        cfg_write(8'h00);
        for (int k = 0; k < NP; k++) begin
            mae = NP'('1) << k;
            #1;
            check(sel == (NP'(1) << k), "R9 lowest port wins", 32'(sel), 32'(1 << k));
        end
        mae = '0; check_route("R10 no mem enable");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule